// File: doc/BRIEF.md
# Debug Telemetry Frame Serializer

This block turns one snapshot of a four-channel touch-sensing front end into a fixed 41-byte serial frame. When the frame trigger is seen, it takes in every channel's 16-bit raw count, baseline and difference value, the four 8-bit parasitic capacitance readings, a firmware revision byte and two status bytes. It holds them in a snapshot register and sends them as asynchronous serial characters on one of four transmit lines. The values themselves are computed elsewhere. This block only freezes, orders and shifts them out.

A per-channel debug-enable mask picks the line. Only the enabled line with the lowest index carries the frame, and every other line stays at the idle-high level. The frame controller has three states. `F_IDLE` waits for a trigger. In `F_LOAD` it hands the next byte to the serializer. In `F_SEND` it waits for that character to finish. The transitions are: capture (`F_IDLE`→`F_LOAD`, on a trigger while at least one channel is enabled), launch (`F_LOAD`→`F_SEND`, always), next-byte (`F_SEND`→`F_LOAD`, character done and bytes remain) and frame-end (`F_SEND`→`F_IDLE`, the 41st character is done). The character serializer has four states. `U_IDLE` waits for a byte. `U_START` drives the start bit, `U_DATA` shifts the eight data bits and `U_STOP` drives the stop bit. Each of `U_START`, `U_DATA` and `U_STOP` lasts `CLKS_PER_BIT` clocks per bit.

Top module: `telem_frame_tx`

## Requirements
- R1: While reset is held, all four transmit lines are high and busy is low.
- R2: Bytes 0 to 5 of a frame are 0x0D, 0x0A, 0x00, the firmware revision, 0x00, and the channel 0 capacitance.
- R3: Bytes 6 to 13 are the raw counts of channels 0, 1, 2 and 3 in that order, each sent as its high byte followed by its low byte.
- R4: Byte 14 is the channel status byte and byte 15 is the output status byte. Each is sent unchanged, so bit 0 (least significant) belongs to channel 0 or output 0.
- R5: Bytes 16 and 17 are 0x00 and the channel 1 capacitance. Bytes 18 to 25 are the four baselines in channel order, high byte first.
- R6: Bytes 26 to 29 are 0x00, the channel 2 capacitance, 0x00 and the channel 3 capacitance. Bytes 30 to 37 are the four difference counts in channel order, high byte first.
- R7: The frame ends with bytes 38 to 40, which are 0x00, 0xFF and 0xFF. After exactly 41 characters, busy returns low.
- R8: Each character is one low start bit, eight data bits sent least significant bit first, and one high stop bit. Every bit lasts `CLKS_PER_BIT` clocks, and the line is high between characters.
- R9: Only the enabled transmit line with the lowest index carries the frame, with channel 0 taking priority over 1, 1 over 2, and 2 over 3. All other lines stay high for the whole frame.
- R10: All frame contents and the chosen line are taken at the trigger. Input changes during a frame do not change the bytes that are sent.
- R11: A trigger that arrives while busy is high is ignored. No second frame follows the current one, and the current one is not disturbed.
- R12: A trigger that arrives while the debug-enable mask is all zero is ignored. Busy stays low and all lines stay high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trig | input | 1 | Frame trigger, sampled on the rising clock edge |
| dbg_en | input | 4 | Debug-enable mask, bit i enables line i |
| fw_rev | input | 8 | Firmware revision byte |
| chan_stat | input | 8 | Channel status byte, bit 0 is channel 0 |
| out_stat | input | 8 | Output status byte, bit 0 is output 0 |
| par_cap | input | 32 | Four 8-bit capacitance values, channel i at bits 8i+7:8i |
| raw_cnt | input | 64 | Four 16-bit raw counts, channel i at bits 16i+15:16i |
| base_cnt | input | 64 | Four 16-bit baselines, same packing as raw_cnt |
| diff_cnt | input | 64 | Four 16-bit difference counts, same packing as raw_cnt |
| tx_line | output | 4 | Serial transmit lines, one per channel, idle high |
| busy | output | 1 | High from the cycle after a capture until the last stop bit ends |

## Verification
The bench decodes every character at the middle of each bit and compares it with a byte list built from the layout rules. An error in the byte order, in the high/low order of a 16-bit word, or in the bit order would show up at a known byte position. It turns on several channels at once to test the priority rule. A wrong priority encoder would put the frame on a higher-index line or on two lines together. In the middle of a frame it scrambles every input and pulses the trigger again. A design without a snapshot would then send mixed data, and one that accepts triggers while busy would start an extra frame after the 41st byte. Finally, a trigger with an empty mask must leave busy low. A design that does not check the mask would raise busy without driving any line.

// File: rtl/telem_pkg.sv
package telem_pkg;

    localparam int NCH       = 4;
    localparam int CNT_W     = 16;
    localparam int CAP_W     = 8;
    localparam int BYTE_W    = 8;
    localparam int FRAME_LEN = 41;
    localparam int IDX_W     = $clog2(FRAME_LEN);

    // byte positions the receiver decodes
    localparam int RAW_AT  = 6;
    localparam int BASE_AT = 18;
    localparam int DIFF_AT = 30;
    localparam int WORD_SPAN = NCH * 2;

    typedef struct packed {
        logic [NCH-1:0][CNT_W-1:0] raw;
        logic [NCH-1:0][CNT_W-1:0] base;
        logic [NCH-1:0][CNT_W-1:0] diff;
        logic [NCH-1:0][CAP_W-1:0] cap;
        logic [BYTE_W-1:0]         fw;
        logic [BYTE_W-1:0]         cstat;
        logic [BYTE_W-1:0]         ostat;
    } snap_t;

    typedef enum logic [1:0] {
        F_IDLE,
        F_LOAD,
        F_SEND
    } frame_state_t;

    typedef enum logic [1:0] {
        U_IDLE,
        U_START,
        U_DATA,
        U_STOP
    } uart_state_t;

endpackage

// File: rtl/telem_snapshot.sv
module telem_snapshot
    import telem_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  load,
    input  logic [NCH-1:0]        mask,
    input  logic [BYTE_W-1:0]     fw_in,
    input  logic [BYTE_W-1:0]     cstat_in,
    input  logic [BYTE_W-1:0]     ostat_in,
    input  logic [NCH*CAP_W-1:0]  cap_in,
    input  logic [NCH*CNT_W-1:0]  raw_in,
    input  logic [NCH*CNT_W-1:0]  base_in,
    input  logic [NCH*CNT_W-1:0]  diff_in,
    output snap_t                 snap_q,
    output logic [NCH-1:0]        lane_q
);

    snap_t          snap_d;
    logic [NCH-1:0] pick;
    logic           seen;

    assign snap_d.raw   = raw_in;
    assign snap_d.base  = base_in;
    assign snap_d.diff  = diff_in;
    assign snap_d.cap   = cap_in;
    assign snap_d.fw    = fw_in;
    assign snap_d.cstat = cstat_in;
    assign snap_d.ostat = ostat_in;

    // lowest enabled index wins
    always_comb begin
        seen = 1'b0;
        pick = '0;
        for (int i = 0; i < NCH; i++) begin
            pick[i] = mask[i] & ~seen;
            seen    = seen | mask[i];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            snap_q <= '0;
            lane_q <= '0;
        end else if (load) begin
            snap_q <= snap_d;
            lane_q <= pick;
        end
    end

endmodule

// File: rtl/telem_frame_map.sv
module telem_frame_map
    import telem_pkg::*;
(
    input  logic [IDX_W-1:0]  idx,
    input  snap_t             snap,
    output logic [BYTE_W-1:0] byte_o
);

    localparam logic [IDX_W-1:0] RAW_LO  = IDX_W'(RAW_AT);
    localparam logic [IDX_W-1:0] BASE_LO = IDX_W'(BASE_AT);
    localparam logic [IDX_W-1:0] DIFF_LO = IDX_W'(DIFF_AT);
    localparam logic [IDX_W-1:0] SPAN    = IDX_W'(WORD_SPAN);

    logic [IDX_W-1:0]        off;
    logic [$clog2(NCH)-1:0]  ch;
    logic [CNT_W-1:0]        word;
    logic                    in_word;

    always_comb begin
        off     = '0;
        word    = '0;
        in_word = 1'b0;
        if (idx >= RAW_LO && idx < RAW_LO + SPAN) begin
            off = idx - RAW_LO;
            in_word = 1'b1;
        end else if (idx >= BASE_LO && idx < BASE_LO + SPAN) begin
            off = idx - BASE_LO;
            in_word = 1'b1;
        end else if (idx >= DIFF_LO && idx < DIFF_LO + SPAN) begin
            off = idx - DIFF_LO;
            in_word = 1'b1;
        end
        ch = off[$clog2(NCH):1];
        if (idx < BASE_LO)
            word = snap.raw[ch];
        else if (idx < DIFF_LO)
            word = snap.base[ch];
        else
            word = snap.diff[ch];
    end

    always_comb begin
        byte_o = 8'h00;
        if (in_word) begin
            // even offset carries the high half
            byte_o = off[0] ? word[7:0] : word[15:8];
        end else begin
            unique case (idx)
                IDX_W'(0):  byte_o = 8'h0D;
                IDX_W'(1):  byte_o = 8'h0A;
                IDX_W'(3):  byte_o = snap.fw;
                IDX_W'(5):  byte_o = snap.cap[0];
                IDX_W'(14): byte_o = snap.cstat;
                IDX_W'(15): byte_o = snap.ostat;
                IDX_W'(17): byte_o = snap.cap[1];
                IDX_W'(27): byte_o = snap.cap[2];
                IDX_W'(29): byte_o = snap.cap[3];
                IDX_W'(39): byte_o = 8'hFF;
                IDX_W'(40): byte_o = 8'hFF;
                default:    byte_o = 8'h00;
            endcase
        end
    end

endmodule

// File: rtl/telem_uart_tx.sv
module telem_uart_tx
    import telem_pkg::*;
#(
    parameter int CLKS_PER_BIT = 434
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [BYTE_W-1:0] data,
    output logic              line,
    output logic              done
);

    localparam int TW = (CLKS_PER_BIT > 1) ? $clog2(CLKS_PER_BIT) : 1;
    localparam logic [TW-1:0] TMAX = TW'(CLKS_PER_BIT - 1);
    localparam int BW = $clog2(BYTE_W);

    uart_state_t       st, st_nx;
    logic [TW-1:0]     tmr;
    logic [BW-1:0]     bit_cnt;
    logic [BYTE_W-1:0] shreg;
    logic              tick;

    assign tick = (tmr == TMAX);

    always_comb begin
        st_nx = st;
        unique case (st)
            U_IDLE:  if (start) st_nx = U_START;
            U_START: if (tick) st_nx = U_DATA;
            U_DATA:  if (tick && bit_cnt == BW'(BYTE_W - 1)) st_nx = U_STOP;
            U_STOP:  if (tick) st_nx = U_IDLE;
            default: st_nx = U_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= U_IDLE;
            tmr     <= '0;
            bit_cnt <= '0;
            shreg   <= '0;
        end else begin
            st <= st_nx;
            if (st == U_IDLE || tick)
                tmr <= '0;
            else
                tmr <= tmr + 1'b1;
            if (st == U_IDLE && start)
                shreg <= data;
            if (st == U_START)
                bit_cnt <= '0;
            if (st == U_DATA && tick) begin
                shreg   <= {1'b0, shreg[BYTE_W-1:1]};
                bit_cnt <= bit_cnt + 1'b1;
            end
        end
    end

    always_comb begin
        line = 1'b1;
        done = 1'b0;
        unique case (st)
            U_IDLE:  line = 1'b1;
            U_START: line = 1'b0;
            U_DATA:  line = shreg[0];
            U_STOP:  begin
                line = 1'b1;
                done = tick;
            end
            default: line = 1'b1;
        endcase
    end

endmodule

// File: rtl/telem_frame_tx.sv
module telem_frame_tx
    import telem_pkg::*;
#(
    parameter int CLKS_PER_BIT = 434
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  trig,
    input  logic [NCH-1:0]        dbg_en,
    input  logic [BYTE_W-1:0]     fw_rev,
    input  logic [BYTE_W-1:0]     chan_stat,
    input  logic [BYTE_W-1:0]     out_stat,
    input  logic [NCH*CAP_W-1:0]  par_cap,
    input  logic [NCH*CNT_W-1:0]  raw_cnt,
    input  logic [NCH*CNT_W-1:0]  base_cnt,
    input  logic [NCH*CNT_W-1:0]  diff_cnt,
    output logic [NCH-1:0]        tx_line,
    output logic                  busy
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_LEN - 1);

    frame_state_t      st, st_nx;
    logic [IDX_W-1:0]  byte_idx;
    logic              capture;
    logic              uart_start;
    logic              uart_done;
    logic              uart_line;
    logic [BYTE_W-1:0] cur_byte;
    snap_t             snap;
    logic [NCH-1:0]    lane_oh;
    logic              last;

    assign capture = (st == F_IDLE) && trig && (|dbg_en);
    assign last    = (byte_idx == LAST_IDX);

    telem_snapshot u_snap (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (capture),
        .mask     (dbg_en),
        .fw_in    (fw_rev),
        .cstat_in (chan_stat),
        .ostat_in (out_stat),
        .cap_in   (par_cap),
        .raw_in   (raw_cnt),
        .base_in  (base_cnt),
        .diff_in  (diff_cnt),
        .snap_q   (snap),
        .lane_q   (lane_oh)
    );

    telem_frame_map u_map (
        .idx    (byte_idx),
        .snap   (snap),
        .byte_o (cur_byte)
    );

    telem_uart_tx #(.CLKS_PER_BIT(CLKS_PER_BIT)) u_uart (
        .clk   (clk),
        .rst_n (rst_n),
        .start (uart_start),
        .data  (cur_byte),
        .line  (uart_line),
        .done  (uart_done)
    );

    always_comb begin
        st_nx = st;
        unique case (st)
            F_IDLE: if (capture) st_nx = F_LOAD;
            F_LOAD: st_nx = F_SEND;
            F_SEND: if (uart_done) st_nx = last ? F_IDLE : F_LOAD;
            default: st_nx = F_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= F_IDLE;
            byte_idx <= '0;
        end else begin
            st <= st_nx;
            if (capture)
                byte_idx <= '0;
            else if (st == F_SEND && uart_done && !last)
                byte_idx <= byte_idx + 1'b1;
        end
    end

    always_comb begin
        busy       = (st != F_IDLE);
        uart_start = (st == F_LOAD);
    end

    for (genvar g = 0; g < NCH; g++) begin : g_lane
        assign tx_line[g] = (busy && lane_oh[g]) ? uart_line : 1'b1;
    end

endmodule

// File: rtl/telem_frame_tx_chk.sv
module telem_frame_tx_chk
    import telem_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             trig,
    input logic [NCH-1:0]   dbg_en,
    input logic             busy,
    input logic [NCH-1:0]   tx_line,
    input logic [NCH-1:0]   lane_oh,
    input logic [IDX_W-1:0] byte_idx,
    input snap_t            snap
);

    localparam logic [NCH-1:0] ONE = {{(NCH-1){1'b0}}, 1'b1};

    AST_IDLE_LINES_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (tx_line == '1)); // R8

    AST_SINGLE_ACTIVE_LANE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~tx_line)); // R9

    AST_LOWEST_LANE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (lane_oh == ($past(dbg_en) & (~$past(dbg_en) + ONE)))); // R9

    AST_START_NEEDS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> ($past(trig) && ($past(dbg_en) != '0))); // R12

    AST_SNAPSHOT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(snap)); // R10

    AST_LANE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(lane_oh)); // R11

    AST_INDEX_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        byte_idx < IDX_W'(FRAME_LEN)); // R7

endmodule

bind telem_frame_tx telem_frame_tx_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .trig     (trig),
    .dbg_en   (dbg_en),
    .busy     (busy),
    .tx_line  (tx_line),
    .lane_oh  (lane_oh),
    .byte_idx (byte_idx),
    .snap     (snap)
);

// File: tb/test_telem_frame_tx.sv
module test_telem_frame_tx;

    localparam int CLK_PERIOD = 10;
    localparam int CPB        = 8;
    localparam int NLEN       = 41;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        trig = 1'b0;
    logic [3:0]  dbg_en = '0;
    logic [7:0]  fw_rev = '0, chan_stat = '0, out_stat = '0;
    logic [31:0] par_cap = '0;
    logic [63:0] raw_cnt = '0, base_cnt = '0, diff_cnt = '0;
    logic [3:0]  tx_line;
    logic        busy;

    int checks = 0;
    int fails  = 0;
    int exp_lane = 0;
    logic [7:0] exp_q[$];
    int         idx_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    telem_frame_tx #(.CLKS_PER_BIT(CPB)) i_telem_frame_tx (
        .clk(clk), .rst_n(rst_n), .trig(trig), .dbg_en(dbg_en),
        .fw_rev(fw_rev), .chan_stat(chan_stat), .out_stat(out_stat),
        .par_cap(par_cap), .raw_cnt(raw_cnt), .base_cnt(base_cnt),
        .diff_cnt(diff_cnt), .tx_line(tx_line), .busy(busy)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    function automatic string req_of(input int i);
        if (i < 6)  return "R2";
        if (i < 14) return "R3";
        if (i < 16) return "R4";
        if (i < 26) return "R5";
        if (i < 38) return "R6";
        return "R7";
    endfunction

    function automatic logic [7:0] word_byte(input logic [63:0] v, input int off);
        logic [15:0] w;
        w = v[(off/2)*16 +: 16];
        return (off % 2 == 0) ? w[15:8] : w[7:0];
    endfunction

    // expected frame from the requirements, using current input values
    function automatic logic [7:0] exp_byte(input int i);
        if (i >= 6  && i < 14) return word_byte(raw_cnt,  i - 6);
        if (i >= 18 && i < 26) return word_byte(base_cnt, i - 18);
        if (i >= 30 && i < 38) return word_byte(diff_cnt, i - 30);
        case (i)
            0:  return 8'h0D;
            1:  return 8'h0A;
            3:  return fw_rev;
            5:  return par_cap[7:0];
            14: return chan_stat;
            15: return out_stat;
            17: return par_cap[15:8];
            27: return par_cap[23:16];
            29: return par_cap[31:24];
            39, 40: return 8'hFF;
            default: return 8'h00;
        endcase
    endfunction

    task automatic set_inputs(input int seed);
        fw_rev    = 8'(seed * 7 + 1);
        chan_stat = 8'(seed * 3 + 5);
        out_stat  = 8'(seed * 11 + 2);
        for (int c = 0; c < 4; c++) begin
            par_cap[c*8 +: 8]   = 8'(seed * 13 + c * 29 + 3);
            raw_cnt[c*16 +: 16]  = 16'(seed * 4099 + c * 257 + 17);
            base_cnt[c*16 +: 16] = 16'(seed * 1021 + c * 771 + 90);
            diff_cnt[c*16 +: 16] = 16'(seed * 613 + c * 4369 + 7);
        end
    endtask

    task automatic pulse_trig;
        @(negedge clk);
        trig = 1'b1;
        @(negedge clk);
        trig = 1'b0;
    endtask

    // driver: push expected bytes, then trigger
    task automatic send_frame(input logic [3:0] mask);
        dbg_en = mask;
        exp_lane = 0;
        for (int c = 3; c >= 0; c--) if (mask[c]) exp_lane = c;
        for (int i = 0; i < NLEN; i++) begin
            exp_q.push_back(exp_byte(i));
            idx_q.push_back(i);
        end
        pulse_trig();
    endtask

    task automatic wait_frame_end;
        int guard;
        guard = 0;
        while (exp_q.size() != 0 && guard < 20000) begin
            @(negedge clk);
            guard++;
        end
        repeat (3 * CPB) @(negedge clk);
        check(busy == 1'b0, "R7 busy low after 41 bytes", busy, 0);
        check(tx_line == 4'hF, "R8 lines idle high after frame", tx_line, 4'hF);
    endtask

    // monitor: decode characters and compare against the queue
    initial begin
        logic [7:0] got;
        int lane;
        int idx;
        forever begin
            @(negedge clk);
            if (rst_n && tx_line != 4'hF) begin
                lane = 0;
                for (int c = 3; c >= 0; c--) if (!tx_line[c]) lane = c;
                check($countones(~tx_line) == 1, "R9 one line active", tx_line, 0);
                check(lane == exp_lane, "R9 lane priority", lane, exp_lane);
                repeat (CPB/2) @(negedge clk);
                check(tx_line[lane] == 1'b0, "R8 start bit", tx_line[lane], 0);
                for (int b = 0; b < 8; b++) begin
                    repeat (CPB) @(negedge clk);
                    got[b] = tx_line[lane];
                end
                repeat (CPB) @(negedge clk);
                check(tx_line[lane] == 1'b1, "R8 stop bit", tx_line[lane], 1);
                if (exp_q.size() == 0) begin
                    check(1'b0, "R11 unexpected extra character", got, 0);
                end else begin
                    idx = idx_q.pop_front();
                    check(got == exp_q[0], $sformatf("%s byte %0d", req_of(idx), idx), got, exp_q[0]);
                    void'(exp_q.pop_front());
                end
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        check(1'b0, "watchdog expired", 0, 1);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        set_inputs(1);
        repeat (4) @(negedge clk);
        // R1: reset state
        check(busy == 1'b0, "R1 busy in reset", busy, 0);
        check(tx_line == 4'hF, "R1 lines in reset", tx_line, 4'hF);
        @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // frame on lane 0
        send_frame(4'b0001);
        wait_frame_end();

        // R3/R6 extremes, R9 lane 1 of {1,2}
        set_inputs(2);
        raw_cnt[15:0]   = 16'hFFFF;
        diff_cnt[63:48] = 16'h0000;
        chan_stat = 8'h01;
        out_stat  = 8'h80;
        send_frame(4'b0110);
        wait_frame_end();

        // R10 + R11: lane 3, inputs scrambled and retrigger mid-frame
        set_inputs(3);
        send_frame(4'b1000);
        repeat (40 * CPB) @(negedge clk);
        check(busy == 1'b1, "R10 busy mid-frame", busy, 1);
        set_inputs(9);
        dbg_en = 4'b0001;
        pulse_trig();
        wait_frame_end();
        repeat (20 * CPB) @(negedge clk);
        check(busy == 1'b0, "R11 no extra frame", busy, 0);
        check(exp_q.size() == 0, "R11 queue drained", exp_q.size(), 0);

        // R12: empty mask trigger ignored
        set_inputs(4);
        dbg_en = 4'b0000;
        pulse_trig();
        repeat (4 * CPB) @(negedge clk);
        check(busy == 1'b0, "R12 busy stays low", busy, 0);
        check(tx_line == 4'hF, "R12 lines stay high", tx_line, 4'hF);

        // R9: all lanes enabled, lane 0 wins
        set_inputs(5);
        send_frame(4'b1111);
        wait_frame_end();

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule